// File: doc/BRIEF.md
# Indexed Factory-Test Register Window

This block gives a host register bus access to a small set of hidden factory-test registers. It uses two host addresses. One holds an index. The other is a data port that reads or writes whichever test register the index selects. Two of the test registers are live snapshots of datapath traffic: the most recent pixel byte sent toward the palette DAC and the most recent byte read from video memory. Both are sampled on every pixel-clock enable.

A third, write-only test register lets software hold the rest of the device in reset and switch off a group of outputs. The block ORs the software reset bit with the hardware reset pin to form the internal reset. The hardware pin alone clears the index and the control bits. Because of this, software that has put the device in reset can still write the bit back to 0 and release it. Host reads are registered: the read data appears on the cycle after the read strobe and carries the value that was held at the strobe.

Top module: `mfg_test_window`

## Requirements
- R1: A host write to address 0x19 loads all 8 bits of the index register. A host read of 0x19 returns the index.
- R2: With index 1, a read of data port 0x18 returns the pixel snapshot. The snapshot loads `dac_pix` on every cycle with `pix_en` high and holds otherwise. A read returns the value held before the strobe edge, even if `pix_en` is high in the same cycle.
- R3: With index 2, a read of 0x18 returns the video-memory snapshot. It loads `vram_data` under the same `pix_en` rule as R2.
- R4: With index 0, 3, 4, or any index above 4, a read of 0x18 returns 0x00.
- R5: A write to 0x18 with any index other than 4 has no effect. The snapshots, `int_rst` and `out_disable` keep their values.
- R6: A write to 0x18 with index 4 sets the software reset bit from data bit 0. The bit keeps its value until the next such write and never clears itself. Data bits 7:2 are ignored.
- R7: A write to 0x18 with index 4 sets `out_disable` from data bit 1. The output changes on the cycle after the write.
- R8: `int_rst` is high whenever `hw_rst` is high or the software reset bit is set. It follows `hw_rst` in the same cycle.
- R9: `hw_rst` clears the index, both control bits, both snapshots and `host_rdata` to zero.
- R10: While `int_rst` is high, both snapshots are held at 0x00, even when `pix_en` is high. A software reset does not clear the index.
- R11: `host_rdata` changes only on the cycle after `host_rd`. A read of any address other than 0x18 or 0x19 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst | input | 1 | Hardware reset pin, active high, synchronous |
| pix_en | input | 1 | Pixel-clock enable; snapshots load when high |
| dac_pix | input | 8 | Pixel byte sent toward the palette DAC |
| vram_data | input | 8 | Byte received from video memory |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered host read data |
| int_rst | output | 1 | Internal reset for the rest of the device |
| out_disable | output | 1 | Disable request for the guarded outputs |

## Verification
The bench builds the block with its default values: 8-bit data and address, index port 0x19 and data port 0x18. With an 8-bit index it can reach indices far above 4, and these must read as zero and ignore writes. Keeping the default port addresses lets the bench probe neighbouring addresses and confirm that they stay silent. The bench also holds the device in software reset with pixel traffic running, and then releases it through the same data port.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
  // Test register indices reached through the data port
  localparam int IDX_NONE = 0;
  localparam int IDX_PIX  = 1;
  localparam int IDX_VRAM = 2;
  localparam int IDX_FMT  = 3;
  localparam int IDX_CTRL = 4;

  // Bit positions inside the write-only control register
  localparam int CTRL_SRST_BIT = 0;
  localparam int CTRL_ODIS_BIT = 1;

  typedef struct packed {
    logic odis;
    logic srst;
  } ctrl_t;
endpackage

// File: rtl/mtw_capture.sv
module mtw_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr)      q <= '0;
    else if (en)  q <= din;
  end
endmodule

// File: rtl/mtw_regfile.sv
module mtw_regfile
  import mtw_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h19,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h18
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  output logic [DATA_W-1:0] index_q,
  output logic              ctrl_wr_evt,
  output ctrl_t             ctrl_q
);
  logic index_wr_evt;

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] target);
    return a == target;
  endfunction

  assign index_wr_evt = host_wr && addr_hit(host_addr, INDEX_ADDR);
  assign ctrl_wr_evt  = host_wr && addr_hit(host_addr, DATA_ADDR)
                        && (index_q == DATA_W'(IDX_CTRL));

  always_ff @(posedge clk) begin
    if (hw_rst)            index_q <= '0;
    else if (index_wr_evt) index_q <= host_wdata;
  end

  // Cleared only by the pin, so a software-held reset can be released
  always_ff @(posedge clk) begin
    if (hw_rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_evt) begin
      ctrl_q.srst <= host_wdata[CTRL_SRST_BIT];
      ctrl_q.odis <= host_wdata[CTRL_ODIS_BIT];
    end
  end
endmodule

// File: rtl/mtw_readport.sv
module mtw_readport
  import mtw_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h19,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h18
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] index_q,
  input  logic [DATA_W-1:0] pix_cap,
  input  logic [DATA_W-1:0] vram_cap,
  output logic [DATA_W-1:0] host_rdata
);
  logic [DATA_W-1:0] test_sel;
  logic [DATA_W-1:0] rd_sel;

  function automatic logic [DATA_W-1:0] pick_test(input logic [DATA_W-1:0] idx,
                                                  input logic [DATA_W-1:0] pix,
                                                  input logic [DATA_W-1:0] vram);
    if (idx == DATA_W'(IDX_PIX))  return pix;
    if (idx == DATA_W'(IDX_VRAM)) return vram;
    return '0;
  endfunction

  assign test_sel = pick_test(index_q, pix_cap, vram_cap);

  always_comb begin
    if (host_addr == INDEX_ADDR)     rd_sel = index_q;
    else if (host_addr == DATA_ADDR) rd_sel = test_sel;
    else                             rd_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (hw_rst)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_sel;
  end
endmodule

// File: rtl/mfg_test_window.sv
module mfg_test_window
  import mtw_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h19,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h18
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              pix_en,
  input  logic [DATA_W-1:0] dac_pix,
  input  logic [DATA_W-1:0] vram_data,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              int_rst,
  output logic              out_disable
);
  logic [DATA_W-1:0] index_q;
  logic              ctrl_wr_evt;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] pix_cap;
  logic [DATA_W-1:0] vram_cap;

  mtw_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_regs (
    .clk(clk), .hw_rst(hw_rst), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_wr(host_wr),
    .index_q(index_q), .ctrl_wr_evt(ctrl_wr_evt), .ctrl_q(ctrl_q)
  );

  assign int_rst     = hw_rst | ctrl_q.srst;
  assign out_disable = ctrl_q.odis;

  mtw_capture #(.WIDTH(DATA_W)) u_pix_cap (
    .clk(clk), .clr(int_rst), .en(pix_en), .din(dac_pix), .q(pix_cap)
  );

  mtw_capture #(.WIDTH(DATA_W)) u_vram_cap (
    .clk(clk), .clr(int_rst), .en(pix_en), .din(vram_data), .q(vram_cap)
  );

  mtw_readport #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_read (
    .clk(clk), .hw_rst(hw_rst), .host_rd(host_rd), .host_addr(host_addr),
    .index_q(index_q), .pix_cap(pix_cap), .vram_cap(vram_cap),
    .host_rdata(host_rdata)
  );
endmodule

// File: rtl/mtw_checker.sv
module mtw_checker #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h18
) (
  input logic              clk,
  input logic              hw_rst,
  input logic              pix_en,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              int_rst,
  input logic              out_disable,
  input logic [DATA_W-1:0] index_q,
  input logic              ctrl_wr_evt,
  input logic [DATA_W-1:0] pix_cap,
  input logic [DATA_W-1:0] vram_cap
);
  logic zero_idx_rd;
  assign zero_idx_rd = host_rd && (host_addr == DATA_ADDR)
                       && (index_q != DATA_W'(1)) && (index_q != DATA_W'(2));

  p_pin_forces_rst_r8: assert property (@(posedge clk) hw_rst |-> int_rst);

  p_soft_rst_set_r6: assert property (@(posedge clk) disable iff (hw_rst)
    (ctrl_wr_evt && host_wdata[0]) |=> int_rst);

  p_odis_stable_r7: assert property (@(posedge clk) disable iff (hw_rst)
    !ctrl_wr_evt |=> $stable(out_disable));

  p_cap_hold_r2: assert property (@(posedge clk) disable iff (hw_rst)
    (!pix_en && !int_rst) |=> ($stable(pix_cap) && $stable(vram_cap)));

  p_cap_clear_r10: assert property (@(posedge clk) disable iff (hw_rst)
    int_rst |=> (pix_cap == '0 && vram_cap == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (hw_rst)
    !host_rd |=> $stable(host_rdata));

  p_zero_index_r4: assert property (@(posedge clk) disable iff (hw_rst)
    zero_idx_rd |=> (host_rdata == '0));
endmodule

bind mfg_test_window mtw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .hw_rst(hw_rst), .pix_en(pix_en), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .int_rst(int_rst), .out_disable(out_disable), .index_q(index_q),
  .ctrl_wr_evt(ctrl_wr_evt), .pix_cap(pix_cap), .vram_cap(vram_cap)
);

// File: tb/tb_mfg_test_window.sv
module tb_mfg_test_window;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [7:0] A_IDX = 8'h19;
  localparam logic [7:0] A_DAT = 8'h18;

  logic       clk = 1'b0;
  logic       hw_rst = 1'b1;
  logic       pix_en = 1'b0;
  logic [7:0] dac_pix = '0, vram_data = '0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       int_rst, out_disable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  mfg_test_window dut (
    .clk(clk), .hw_rst(hw_rst), .pix_en(pix_en), .dac_pix(dac_pix),
    .vram_data(vram_data), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .int_rst(int_rst), .out_disable(out_disable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_seen <= host_rd;

  // Monitor: data from a read strobe is visible one edge later
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (host_rdata !== e) begin
        errors++;
        $display("FAIL %s: host_rdata actual %02h expected %02h", t, host_rdata, e);
      end
    end
  end

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; pix_en = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0; pix_en = 1'b0;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // Driver: strobe a read and push the expected byte for the monitor
  task automatic host_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_addr = a; host_wr = 1'b0; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pixel(input logic [7:0] p, input logic [7:0] v);
    @(negedge clk);
    dac_pix = p; vram_data = v; pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: pin reset drives internal reset combinationally
    check1("R8 int_rst during hw_rst", int_rst, 1'b1);
    hw_rst = 1'b0;
    #1;
    check1("R8 int_rst follows pin", int_rst, 1'b0);
    // R9: reset state
    check1("R9 out_disable reset", out_disable, 1'b0);
    check8("R9 rdata reset", host_rdata, 8'h00);
    host_read(A_IDX, 8'h00, "R9 index reset");

    // R1: index write/readback
    host_write(A_IDX, 8'hA7);
    host_read(A_IDX, 8'hA7, "R1 index readback");

    // R2/R3: snapshots
    pixel(8'h3C, 8'hC5);
    host_write(A_IDX, 8'h01);
    host_read(A_DAT, 8'h3C, "R2 pixel snapshot");
    host_write(A_IDX, 8'h02);
    host_read(A_DAT, 8'hC5, "R3 vram snapshot");

    // R2: read returns value held at strobe, new pixel lands same cycle
    host_write(A_IDX, 8'h01);
    @(negedge clk);
    host_addr = A_DAT; host_rd = 1'b1; pix_en = 1'b1; dac_pix = 8'h91; vram_data = 8'h19;
    exp_q.push_back(8'h3C); tag_q.push_back("R2 read before same-cycle update");
    @(negedge clk);
    host_rd = 1'b0; pix_en = 1'b0; dac_pix = 8'hEE;
    @(negedge clk);
    host_read(A_DAT, 8'h91, "R2 updated snapshot");
    // R2: no pix_en, no update
    dac_pix = 8'h42; vram_data = 8'h24;
    repeat (3) idle();
    host_read(A_DAT, 8'h91, "R2 hold without pix_en");
    host_write(A_IDX, 8'h02);
    host_read(A_DAT, 8'h19, "R3 hold without pix_en");

    // R4: indices that read as zero
    host_write(A_IDX, 8'h00); host_read(A_DAT, 8'h00, "R4 index 0");
    host_write(A_IDX, 8'h03); host_read(A_DAT, 8'h00, "R4 index 3");
    host_write(A_IDX, 8'h04); host_read(A_DAT, 8'h00, "R4 index 4");
    host_write(A_IDX, 8'hF2); host_read(A_DAT, 8'h00, "R4 index F2");

    // R5: writes through other indices are ignored
    host_write(A_IDX, 8'h01); host_write(A_DAT, 8'h03);
    host_write(A_IDX, 8'h02); host_write(A_DAT, 8'h03);
    host_write(A_IDX, 8'h05); host_write(A_DAT, 8'h03);
    host_write(A_IDX, 8'h00); host_write(A_DAT, 8'h03);
    check1("R5 int_rst unchanged", int_rst, 1'b0);
    check1("R5 out_disable unchanged", out_disable, 1'b0);
    host_write(A_IDX, 8'h01); host_read(A_DAT, 8'h91, "R5 pixel snapshot kept");
    host_write(A_IDX, 8'h02); host_read(A_DAT, 8'h19, "R5 vram snapshot kept");

    // R11: other addresses read zero; rdata held between reads
    host_read(8'h1A, 8'h00, "R11 other address");
    pixel(8'h77, 8'h66);
    repeat (2) idle();
    check8("R11 rdata held", host_rdata, 8'h00);

    // R7: output disable via bit 1, upper bits ignored
    host_write(A_IDX, 8'h04);
    host_write(A_DAT, 8'hFE);
    check1("R7 out_disable set", out_disable, 1'b1);
    check1("R6 bit0 clear keeps int_rst low", int_rst, 1'b0);
    host_write(A_DAT, 8'h00);
    check1("R7 out_disable cleared", out_disable, 1'b0);

    // R6/R10: software reset held, snapshots cleared, released by software
    host_write(A_DAT, 8'hFD);
    check1("R6 soft reset set", int_rst, 1'b1);
    check1("R6 bits 7:2 ignored", out_disable, 1'b0);
    pixel(8'h5A, 8'hA5);
    repeat (4) idle();
    check1("R6 soft reset persists", int_rst, 1'b1);
    host_read(A_IDX, 8'h04, "R10 index survives soft reset");
    host_write(A_IDX, 8'h01); host_read(A_DAT, 8'h00, "R10 pixel held zero");
    host_write(A_IDX, 8'h02); host_read(A_DAT, 8'h00, "R10 vram held zero");
    host_write(A_IDX, 8'h04);
    host_write(A_DAT, 8'h00);
    check1("R6 soft reset released", int_rst, 1'b0);
    pixel(8'h5A, 8'hA5);
    host_write(A_IDX, 8'h01); host_read(A_DAT, 8'h5A, "R10 capture resumes");

    // R9: pin reset clears everything set so far
    host_write(A_IDX, 8'h04);
    host_write(A_DAT, 8'h03);
    check1("R8 soft reset drives int_rst", int_rst, 1'b1);
    host_write(A_IDX, 8'h02);
    host_read(A_IDX, 8'h02, "R1 index before pin reset");
    @(negedge clk); hw_rst = 1'b1;
    @(negedge clk); hw_rst = 1'b0;
    #1;
    check1("R9 soft reset cleared", int_rst, 1'b0);
    check1("R9 out_disable cleared", out_disable, 1'b0);
    check8("R9 rdata cleared", host_rdata, 8'h00);
    host_read(A_IDX, 8'h00, "R9 index cleared");
    host_write(A_IDX, 8'h02); host_read(A_DAT, 8'h00, "R9 vram snapshot cleared");

    repeat (3) idle();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule